// File: doc/BRIEF.md
# Converter Result Holding Register with Paired-Byte Read Lock

This block stores the most recent 10-bit converter result and shows it to an 8-bit bus as two bytes, a low byte and a high byte. A control bit selects how the result is arranged. Right justification places the result at the bottom of the 16-bit pair. Left justification places it at the top, so that software that needs only 8 bits of precision reads the high byte alone.

Software reads a full result in two bus reads, low byte first. That low-byte read freezes both bytes until the high-byte read, so the two halves always come from the same conversion. A conversion that finishes while the bytes are frozen is discarded. The completion interrupt request still pulses for that conversion.

A two-state controller does the freezing. In `S_OPEN`, conversions write the store. The transition LOCK_ON_LOW_READ (a low read without a high read) moves it to `S_HELD`. In `S_HELD`, writes are blocked. The transition RELEASE_ON_HIGH_READ (any high read) returns it to `S_OPEN`. In any other case the controller stays in its current state.

Top module: `adc_result_latch`

## Requirements
- R1: With `left_just`=0, `lo_byte` = result[7:0] and `hi_byte`[1:0] = result[9:8].
- R2: With `left_just`=1, `hi_byte` = result[9:2] and `lo_byte`[7:6] = result[1:0].
- R3: A `rd_lo` pulse without `rd_hi` in the same cycle locks the store from the next clock edge onward.
- R4: While the store is locked, a `conv_done` pulse leaves both bytes unchanged, and that result is lost.
- R5: A `rd_hi` pulse releases the lock from the next clock edge, so later conversions update the bytes again.
- R6: `done_irq` is high in the cycle after every `conv_done` pulse, including pulses whose result was dropped.
- R7: A `rd_hi` pulse with no earlier `rd_lo` does not lock, and the next conversion still updates the bytes.
- R8: Bits not occupied by the result read as zero: `hi_byte`[7:2] when right-justified, `lo_byte`[5:0] when left-justified.
- R9: Changing `left_just` rearranges the stored result on the outputs in the same cycle, without a new conversion.
- R10: Reset (`rst_n` low, asynchronous) clears both bytes, releases the lock and deasserts `done_irq`.
- R11: When unlocked, a result given with `conv_done` appears on the bytes in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: conversion finished |
| conv_result | input | 10 | Result accompanying `conv_done` |
| left_just | input | 1 | 1 = left-justified, 0 = right-justified |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| lo_byte | output | 8 | Low byte read value |
| hi_byte | output | 8 | High byte read value |
| done_irq | output | 1 | Completion interrupt request, one-cycle pulse |

## Verification
The assertions assume that `conv_done`, `rd_lo` and `rd_hi` are clean synchronous pulses. They also assume that a read and a completion may land in the same cycle, and that when both read strobes are high together the high read wins. The stimulus changes inputs only half a cycle after each rising edge. It mixes isolated pulses with deliberate collisions: a completion in the same cycle as a low read, and a completion in the same cycle as a high read. It keeps every input driven to a known level from time zero.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;
    typedef enum logic {
        S_OPEN = 1'b0,
        S_HELD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/adc_lock_ctl.sv
module adc_lock_ctl
    import adc_result_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    input  logic rd_lo,
    input  logic rd_hi,
    output logic store_we,
    output logic locked
);
    lock_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN: if (rd_lo && !rd_hi) state_d = S_HELD;   // LOCK_ON_LOW_READ
            S_HELD: if (rd_hi)           state_d = S_OPEN;   // RELEASE_ON_HIGH_READ
            default:                     state_d = S_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OPEN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        store_we = 1'b0;
        locked   = 1'b0;
        unique case (state_q)
            S_OPEN: store_we = conv_done;
            S_HELD: locked   = 1'b1;
            default: ;
        endcase
    end

    AST_LOW_READ_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !rd_hi) |=> locked);                                // R3
    AST_HIGH_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> !locked);                                           // R5
    AST_HELD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !store_we);                                        // R4
endmodule

// File: rtl/adc_byte_fmt.sv
module adc_byte_fmt #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  res,
    input  logic              left_just,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] pair_r, pair_l, pair;

    assign pair_r = {{PAD_W{1'b0}}, res};
    assign pair_l = {res, {PAD_W{1'b0}}};

    always_comb begin
        pair    = left_just ? pair_l : pair_r;
        lo_byte = pair[BYTE_W-1:0];
        hi_byte = pair[PAIR_W-1:BYTE_W];
    end
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              left_just,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte,
    output logic              done_irq
);
    localparam int PAD_W = 2 * BYTE_W - RES_W;

    logic             store_we;
    logic             locked;
    logic [RES_W-1:0] res_q;

    adc_lock_ctl u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_done(conv_done),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .store_we (store_we),
        .locked   (locked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q    <= '0;
            done_irq <= 1'b0;
        end else begin
            done_irq <= conv_done;
            if (store_we) res_q <= conv_result;
        end
    end

    adc_byte_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
        .res      (res_q),
        .left_just(left_just),
        .lo_byte  (lo_byte),
        .hi_byte  (hi_byte)
    );

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(res_q));                                   // R4
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> done_irq);                                      // R6
    AST_IRQ_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> !done_irq);                                    // R6
    AST_OPEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !locked) |=> (res_q == $past(conv_result)));    // R11
    AST_PAD_ZERO_R: assert property (@(posedge clk) disable iff (!rst_n)
        !left_just |-> (hi_byte[BYTE_W-1:RES_W-BYTE_W] == '0));       // R8
    AST_PAD_ZERO_L: assert property (@(posedge clk) disable iff (!rst_n)
        left_just |-> (lo_byte[PAD_W-1:0] == '0));                    // R8
endmodule

// File: tb/adc_result_latch_tb.sv
module adc_result_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic       left_just = 1'b0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] lo_byte, hi_byte;
    logic       done_irq;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  cycles = 0;
    bit  done_flag = 0;
    string phase = "R10 reset";

    // behavioural reference state
    int m_res = 0;
    bit m_lock = 0;
    bit m_irq = 0;

    always #4 clk = ~clk;   // 125 MHz

    adc_result_latch dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
        .left_just(left_just), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .lo_byte(lo_byte), .hi_byte(hi_byte), .done_irq(done_irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_res = 0; m_lock = 0; m_irq = 0;
        end else begin
            m_irq = conv_done;
            if (conv_done && !m_lock) m_res = conv_result;
            if (rd_hi) m_lock = 0;
            else if (rd_lo) m_lock = 1;
        end
    end

    function automatic int exp_pair(int r, bit lj);
        return lj ? (r << 6) : r;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // compare on every clock, half a cycle after the edge
    always @(negedge clk) begin
        int p;
        if (!done_flag) begin
            cycles++;
            p = exp_pair(m_res, left_just);
            check({phase, " lo_byte"}, lo_byte, p & 255);
            check({phase, " hi_byte"}, hi_byte, (p >> 8) & 255);
            check({phase, " done_irq (R6)"}, done_irq, m_irq);
            if (cycles > 100000) begin
                n_bad++; n_cmp++;
                $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
                done_flag = 1;
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    task automatic step(bit d, int v, bit lo, bit hi);
        @(negedge clk); #1;
        conv_done = d; conv_result = v[9:0]; rd_lo = lo; rd_hi = hi;
        @(negedge clk); #1;
        conv_done = 0; rd_lo = 0; rd_hi = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state checked by the per-clock compare above
        check("R10 reset lo", lo_byte, 0);
        check("R10 reset hi", hi_byte, 0);
        #1 rst_n = 1;

        phase = "R11/R1 right update";
        step(1, 10'h2A5, 0, 0);
        step(1, 10'h3FF, 0, 0);
        phase = "R2/R8 left";
        left_just = 1;
        step(0, 0, 0, 0);
        phase = "R9 live swap";
        @(negedge clk); #1 left_just = 0;
        @(negedge clk); #1 left_just = 1;
        step(1, 10'h155, 0, 0);
        left_just = 0;

        phase = "R3/R4 lock drops result";
        step(0, 0, 1, 0);
        step(1, 10'h0F0, 0, 0);
        step(1, 10'h201, 0, 0);
        phase = "R6 irq on dropped";
        step(1, 10'h111, 0, 1);    // high read and done together: still dropped
        phase = "R5 unlock";
        step(1, 10'h0CC, 0, 0);
        phase = "R3 collide lo+done";
        step(1, 10'h333, 1, 0);    // written, then locked
        step(1, 10'h044, 0, 0);
        step(0, 0, 0, 1);
        phase = "R7 high alone no lock";
        step(0, 0, 0, 1);
        step(1, 10'h1E7, 0, 0);
        phase = "R5 both reads";
        step(0, 0, 1, 1);
        step(1, 10'h08A, 0, 0);

        phase = "R1/R2/R4 mixed";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1;
            conv_done = $urandom_range(0, 1);
            conv_result = 10'($urandom);
            rd_lo = ($urandom_range(0, 3) == 0);
            rd_hi = ($urandom_range(0, 3) == 0);
            left_just = ($urandom_range(0, 5) == 0) ? ~left_just : left_just;
        end
        @(negedge clk); #1;
        conv_done = 0; rd_lo = 0; rd_hi = 0;

        phase = "R10 mid reset";
        step(0, 0, 1, 0);
        #1 rst_n = 0;
        @(negedge clk);
        #1 rst_n = 1;
        step(1, 10'h3C3, 0, 0);    // proves lock released by reset
        repeat (2) @(negedge clk);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule